// File: doc/BRIEF.md
# FSK Cycle-Count Tag Demodulator

This block recovers a 44-bit identifier from a proximity tag that answers by frequency-shift keying its load at two sub-carriers: one cycle every 8 carrier periods and one every 10. It takes a stream of 8-bit envelope samples, one per carrier period, each qualified by a valid strobe. It slices each sample to a logic level. It times the distance between rising edges and sorts every sub-carrier cycle into the short (8) or long (10) class.

Runs of equal classes are turned into half-bit symbols. A short-class run stands for symbol 1 and a long-class run for symbol 0. The run length is divided by the cycles that make up a half-bit, with rounding, so jittered periods and the lone short cycle that the tag slips in ahead of every nibble drop out. The half-bit stream is searched for the frame marker. Between two markers the symbols are taken in pairs and Manchester-decoded into a 44-bit register, most significant bit first. When the next marker arrives and the collected value is non-zero, the value is presented with a one-clock valid pulse.

The enable input gates the whole datapath. Dropping it returns every stage, including the output register, to its reset state, so software can restart a capture cleanly.

Top module: `fsk_tag_demod`

## Requirements
- R1: A sample of 127 or more slices to level 1; a sample of 126 or less slices to level 0.
- R2: A sample is taken only in a clock where `smp_valid` is high; sample values in other clocks have no effect on the decoded ID.
- R3: No cycle is timed before the first 0-to-1 level change. Each later rising edge closes one cycle whose length is the count of taken samples since the previous rising edge. A length below 9 is the short class, and 9 or more is the long class.
- R4: A run of n consecutive short-class cycles yields floor((n+1)/6) half-bits of symbol 1. A run of n long-class cycles yields floor((n+1)/5) half-bits of symbol 0. A single short cycle between two runs therefore yields nothing.
- R5: A run whose half-bit count is outside 1 to 4 yields no half-bits at all, so a run of 36 short cycles cannot form a frame marker.
- R6: The half-bit sequence 1,1,1,0,0,0 (oldest first) is the frame marker. After it, pair 0,1 decodes as bit 1 and pair 1,0 as bit 0, shifted into the 44-bit register at the least significant end so the first bit received ends up most significant.
- R7: On each marker that ends an unbroken frame, the register's value is reported if it is non-zero, and the register is then cleared. An all-zero value is never reported.
- R8: A pair 0,0 inside a frame, or a pair 1,1 that does not continue into a marker, abandons the frame. No report is made until a later frame is decoded from one marker to the next.
- R9: `id_valid` is high for exactly one clock per report, and `id_out` changes only in that clock and then holds its value.
- R10: While `en` is low, all decoding state and `id_out` return to their reset values and samples are ignored. `id_valid` is low in the clock after any clock with `en` low.
- R11: After reset, `id_valid` is 0 and `id_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Decoder enable; low clears all state |
| smp_valid | input | 1 | Qualifies `smp` in this clock |
| smp | input | 8 | Envelope sample |
| id_out | output | 44 | Last reported tag ID |
| id_valid | output | 1 | One-clock pulse when `id_out` is updated |

## Verification
The bench builds the block with its default parameters: a slicing level of 127, a class split at 9, a 5-bit period counter, a 6-bit run counter and a 44-bit ID. With these values the run counter reaches 36 cycles without saturating, so an over-long run can be shown to yield nothing. Periods of 7 to 11 samples, gaps in the valid strobe, and samples sitting exactly at 126 and 127 stay within reach of a single encoded frame. The frames come from an encoder model written in the bench, which lets a corrupted pair, a missing marker and an all-zero ID each be placed in an otherwise clean stream.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;

  // Frame decoder states
  typedef enum logic [1:0] {
    FR_HUNT  = 2'd0,  // searching for a frame marker
    FR_DATA  = 2'd1,  // Manchester pairs being collected
    FR_PEND1 = 2'd2,  // saw pair 1,1: may be the head of the next marker
    FR_PEND2 = 2'd3   // saw 1,1 then 1,0: marker tail 0,0 expected
  } frame_st_e;

  // Half-bit window, oldest symbol in bit 5
  localparam logic [5:0] SOF_MARK = 6'b111000;

  // Cycles per half-bit for each sub-carrier class
  localparam int unsigned SHORT_PER_HALF = 6;
  localparam int unsigned LONG_PER_HALF  = 5;

  // Largest half-bit count a single run may produce
  localparam int unsigned MAX_HALVES = 4;

endpackage

// File: rtl/fsk_cycle_meter.sv
module fsk_cycle_meter #(
  parameter int unsigned SMP_W  = 8,
  parameter int unsigned THRESH = 127,
  parameter int unsigned SPLIT  = 9,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp,
  output logic             cyc_valid,
  output logic             cyc_short
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SMP_W-1:0] LVL_TH  = SMP_W'(THRESH);
  localparam logic [CNT_W-1:0] CLS_TH  = CNT_W'(SPLIT);

  logic             lvl_q, lvl_d;     // previous sliced level
  logic             sync_q, sync_d;   // first rising edge seen
  logic [CNT_W-1:0] cnt_q, cnt_d;     // samples since last rising edge
  logic             cv_q, cv_d;
  logic             cs_q, cs_d;

  logic lvl_now;
  logic rise;
  logic upd;

  assign lvl_now = (smp >= LVL_TH);
  assign rise    = lvl_now & ~lvl_q;
  assign upd     = clr | smp_valid;

  always_comb begin
    lvl_d  = lvl_q;
    sync_d = sync_q;
    cnt_d  = cnt_q;
    cv_d   = 1'b0;
    cs_d   = cs_q;
    if (clr) begin
      lvl_d  = 1'b1;  // a stream that opens high is not an edge
      sync_d = 1'b0;
      cnt_d  = '0;
      cs_d   = 1'b0;
    end else if (smp_valid) begin
      lvl_d = lvl_now;
      if (rise) begin
        if (sync_q) begin
          cv_d = 1'b1;
          cs_d = (cnt_q < CLS_TH);
        end
        sync_d = 1'b1;
        cnt_d  = CNT_W'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      sync_q <= 1'b0;
      cnt_q  <= '0;
      cs_q   <= 1'b0;
    end else if (upd) begin
      lvl_q  <= lvl_d;
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      cs_q   <= cs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cv_q <= 1'b0;
    else        cv_q <= cv_d;
  end

  assign cyc_valid = cv_q;
  assign cyc_short = cs_q;

  // R2: a classified cycle always follows a taken sample
  assert_valid_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> $past(smp_valid && !clr));

endmodule

// File: rtl/fsk_run_slicer.sv
module fsk_run_slicer
  import fsk_demod_pkg::*;
#(
  parameter int unsigned RUN_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cyc_valid,
  input  logic cyc_short,
  output logic hb_valid,
  output logic hb_sym
);

  localparam int unsigned NW = RUN_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic             have_q, have_d;   // a run is open
  logic             cls_q, cls_d;     // class of the open run (1 = short)
  logic [RUN_W-1:0] n_q, n_d;         // cycles in the open run
  logic             sym_q, sym_d;     // symbol being replayed
  logic [2:0]       rem_q, rem_d;     // half-bits still to replay

  logic [NW-1:0] n_plus;
  logic [NW-1:0] halves;
  logic          close_run;
  logic          count_ok;
  logic          upd;

  assign n_plus    = {1'b0, n_q} + NW'(1);
  assign halves    = cls_q ? (n_plus / NW'(SHORT_PER_HALF))
                           : (n_plus / NW'(LONG_PER_HALF));
  assign count_ok  = (halves != '0) && (halves <= NW'(MAX_HALVES));
  assign close_run = cyc_valid & have_q & (cyc_short != cls_q);
  assign upd       = clr | cyc_valid | (rem_q != 3'd0);

  always_comb begin
    have_d = have_q;
    cls_d  = cls_q;
    n_d    = n_q;
    sym_d  = sym_q;
    rem_d  = rem_q;
    if (clr) begin
      have_d = 1'b0;
      cls_d  = 1'b0;
      n_d    = '0;
      sym_d  = 1'b0;
      rem_d  = 3'd0;
    end else begin
      if (rem_q != 3'd0) rem_d = rem_q - 3'd1;
      if (cyc_valid) begin
        if (!have_q || close_run) begin
          have_d = 1'b1;
          cls_d  = cyc_short;
          n_d    = RUN_W'(1);
        end else if (n_q != RUN_MAX) begin
          n_d = n_q + RUN_W'(1);
        end
      end
      if (close_run && count_ok) begin
        sym_d = cls_q;
        rem_d = halves[2:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      cls_q  <= 1'b0;
      n_q    <= '0;
      sym_q  <= 1'b0;
      rem_q  <= 3'd0;
    end else if (upd) begin
      have_q <= have_d;
      cls_q  <= cls_d;
      n_q    <= n_d;
      sym_q  <= sym_d;
      rem_q  <= rem_d;
    end
  end

  assign hb_valid = (rem_q != 3'd0);
  assign hb_sym   = sym_q;

  // R4: a fresh burst of half-bits starts only after a classified cycle
  assert_burst_after_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_valid && !$past(hb_valid)) |-> $past(cyc_valid));

endmodule

// File: rtl/fsk_frame_decoder.sv
module fsk_frame_decoder
  import fsk_demod_pkg::*;
#(
  parameter int unsigned ID_W = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            hb_valid,
  input  logic            hb_sym,
  output logic [ID_W-1:0] id_out,
  output logic            id_valid
);

  logic [5:0]      win_q, win_d;
  frame_st_e       st_q, st_d;
  logic            ph_q, ph_d;       // 1 = first half of a pair is held
  logic            first_q, first_d;
  logic [ID_W-1:0] acc_q, acc_d;
  logic [ID_W-1:0] id_q, id_d;
  logic            v_q, v_d;

  logic [5:0] win_next;
  logic       marker;
  logic       upd;

  assign win_next = {win_q[4:0], hb_sym};
  assign marker   = (win_next == SOF_MARK);
  assign upd      = clr | hb_valid;

  always_comb begin
    win_d   = win_q;
    st_d    = st_q;
    ph_d    = ph_q;
    first_d = first_q;
    acc_d   = acc_q;
    id_d    = id_q;
    v_d     = 1'b0;
    if (clr) begin
      win_d   = '0;
      st_d    = FR_HUNT;
      ph_d    = 1'b0;
      first_d = 1'b0;
      acc_d   = '0;
      id_d    = '0;
    end else if (hb_valid) begin
      win_d = win_next;
      if (marker) begin
        if ((st_q != FR_HUNT) && (acc_q != '0)) begin
          id_d = acc_q;
          v_d  = 1'b1;
        end
        acc_d = '0;
        st_d  = FR_DATA;
        ph_d  = 1'b0;
      end else if (st_q != FR_HUNT) begin
        if (!ph_q) begin
          first_d = hb_sym;
          ph_d    = 1'b1;
        end else begin
          ph_d = 1'b0;
          case (st_q)
            FR_DATA: begin
              if (first_q != hb_sym)  acc_d = {acc_q[ID_W-2:0], hb_sym};
              else if (first_q)       st_d  = FR_PEND1;
              else                    st_d  = FR_HUNT;
            end
            FR_PEND1: st_d = (first_q && !hb_sym) ? FR_PEND2 : FR_HUNT;
            default:  st_d = FR_HUNT;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      st_q    <= FR_HUNT;
      ph_q    <= 1'b0;
      first_q <= 1'b0;
      acc_q   <= '0;
      id_q    <= '0;
    end else if (upd) begin
      win_q   <= win_d;
      st_q    <= st_d;
      ph_q    <= ph_d;
      first_q <= first_d;
      acc_q   <= acc_d;
      id_q    <= id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  assign id_out   = id_q;
  assign id_valid = v_q;

  // R9: one-clock report pulse
  assert_pulse_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  // R9: the reported value holds between reports
  assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid && !$past(clr)) |-> $stable(id_out));

  // R7: a report is caused by the closing 0 of a marker
  assert_report_on_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> $past(hb_valid && !hb_sym && !clr));

endmodule

// File: rtl/fsk_tag_demod.sv
module fsk_tag_demod #(
  parameter int unsigned SMP_W  = 8,
  parameter int unsigned THRESH = 127,
  parameter int unsigned SPLIT  = 9,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned RUN_W  = 6,
  parameter int unsigned ID_W   = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp,
  output logic [ID_W-1:0]  id_out,
  output logic             id_valid
);

  logic clr;
  logic cyc_valid;
  logic cyc_short;
  logic hb_valid;
  logic hb_sym;

  assign clr = ~en;

  fsk_cycle_meter #(
    .SMP_W (SMP_W),
    .THRESH(THRESH),
    .SPLIT (SPLIT),
    .CNT_W (CNT_W)
  ) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .smp_valid(smp_valid),
    .smp      (smp),
    .cyc_valid(cyc_valid),
    .cyc_short(cyc_short)
  );

  fsk_run_slicer #(
    .RUN_W(RUN_W)
  ) u_slicer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cyc_valid(cyc_valid),
    .cyc_short(cyc_short),
    .hb_valid (hb_valid),
    .hb_sym   (hb_sym)
  );

  fsk_frame_decoder #(
    .ID_W(ID_W)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .hb_valid(hb_valid),
    .hb_sym  (hb_sym),
    .id_out  (id_out),
    .id_valid(id_valid)
  );

  // R10: no report in the clock after the enable is low
  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !id_valid);

endmodule

// File: tb/fsk_tag_demod_tb.sv
`timescale 1ns/1ps
module fsk_tag_demod_tb;

  localparam int ID_W = 44;

  // stimulus modes
  localparam logic [2:0] M_CLEAN = 3'd0;
  localparam logic [2:0] M_JIT   = 3'd1;
  localparam logic [2:0] M_EDGE  = 3'd2;
  localparam logic [2:0] M_CORR  = 3'd3;
  localparam logic [2:0] M_LONG  = 3'd4;

  typedef struct packed {
    logic [43:0] id;
    logic [2:0]  mode;
    logic [1:0]  frames;
    logic [1:0]  pulses;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{44'h0A5_0F3C_9E71, M_CLEAN, 2'd2, 2'd2},
    '{44'h000_0000_0001, M_CLEAN, 2'd2, 2'd2},
    '{44'hFFF_FFFF_FFFF, M_CLEAN, 2'd2, 2'd2},
    '{44'h8C3_5A69_0F0E, M_JIT,   2'd2, 2'd2},
    '{44'h123_4567_89AB, M_EDGE,  2'd2, 2'd2},
    '{44'h000_0000_0000, M_CLEAN, 2'd2, 2'd0},
    '{44'h5D2_6B19_0E47, M_CORR,  2'd3, 2'd2},
    '{44'h3A7_C01D_55E3, M_LONG,  2'd3, 2'd1}
  };

  logic            clk;
  logic            rst_n;
  logic            en;
  logic            smp_valid;
  logic [7:0]      smp;
  logic [ID_W-1:0] id_out;
  logic            id_valid;

  fsk_tag_demod u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .smp_valid(smp_valid),
    .smp      (smp),
    .id_out   (id_out),
    .id_valid (id_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // output monitor
  int              pulses    = 0;
  int              mism      = 0;
  int              width_err = 0;
  logic            prev_v    = 1'b0;
  logic [ID_W-1:0] exp_id    = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (id_valid) begin
        pulses = pulses + 1;
        if (id_out != exp_id) mism = mism + 1;
        if (prev_v) width_err = width_err + 1;
      end
      prev_v = id_valid;
    end
  end

  // stimulus shaping
  logic [7:0] lvl_hi  = 8'd200;
  logic [7:0] lvl_lo  = 8'd40;
  bit         jit     = 1'b0;
  int         gap_ctr = 0;
  int         jit_ctr = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic put(input logic [7:0] v);
    smp       = v;
    smp_valid = 1'b1;
    @(negedge clk);
    if (jit) begin
      gap_ctr = gap_ctr + 1;
      if (gap_ctr % 3 == 0) begin
        smp       = 8'hFF;   // must be ignored (R2)
        smp_valid = 1'b0;
        @(negedge clk);
      end
    end
  endtask

  task automatic cyc(input bit short_c);
    int len;
    int hc;
    if (jit) begin
      len = short_c ? ((jit_ctr % 2 == 0) ? 7 : 8) : (9 + (jit_ctr % 3));
      jit_ctr = jit_ctr + 1;
    end else begin
      len = short_c ? 8 : 10;
    end
    hc = short_c ? 2 : 3;
    for (int k = 0; k < len; k++) put((k < hc) ? lvl_hi : lvl_lo);
  endtask

  task automatic half(input bit one);
    repeat (one ? 6 : 5) cyc(one);
  endtask

  task automatic marker_and_lead();
    half(1); half(1); half(1); half(0); half(0); half(0);
    half(1); half(0);
  endtask

  task automatic long_run_and_lead();
    repeat (36) cyc(1);
    half(0); half(0); half(0);
    half(1); half(0);
  endtask

  task automatic data(input logic [43:0] id, input bit corrupt);
    for (int i = 43; i >= 0; i--) begin
      if (i % 4 == 3) cyc(1);
      if (corrupt && i == 20) begin half(0); half(0); end
      else if (id[i])         begin half(0); half(1); end
      else                    begin half(1); half(0); end
    end
  endtask

  task automatic stream(input logic [43:0] id, input logic [2:0] mode, input int nfr);
    repeat (4) put(lvl_lo);
    for (int f = 0; f < nfr; f++) begin
      if (mode == M_LONG && f == 1) long_run_and_lead();
      else                          marker_and_lead();
      data(id, (mode == M_CORR) && (f == 0));
    end
    marker_and_lead();
    cyc(1); cyc(1);
    smp_valid = 1'b0;
    smp       = 8'd0;
    repeat (40) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] mode);
    jit     = (mode == M_JIT);
    gap_ctr = 0;
    jit_ctr = 0;
    if (mode == M_EDGE)     begin lvl_hi = 8'd127; lvl_lo = 8'd126; end
    else if (mode == M_JIT) begin lvl_hi = 8'd255; lvl_lo = 8'd0;   end
    else                    begin lvl_hi = 8'd200; lvl_lo = 8'd40;  end
  endtask

  task automatic restart();
    en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.id == '0)          return "R7";
    case (v.mode)
      M_JIT:   return "R2 R3";
      M_EDGE:  return "R1";
      M_CORR:  return "R8";
      M_LONG:  return "R5";
      default: return "R4 R6";
    endcase
  endfunction

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int p0;
    int m0;
    rst_n     = 1'b0;
    en        = 1'b0;
    smp_valid = 1'b0;
    smp       = 8'd0;
    repeat (5) @(negedge clk);

    // R11: reset state
    chk(id_valid == 1'b0, "R11", "id_valid in reset", id_valid, 0);
    chk(id_out == '0,     "R11", "id_out in reset",   id_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(id_valid == 1'b0 && id_out == '0, "R11", "outputs after release", id_out, 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      set_mode(VECS[v].mode);
      restart();
      exp_id = VECS[v].id;
      p0 = pulses;
      m0 = mism;
      stream(VECS[v].id, VECS[v].mode, int'(VECS[v].frames));
      chk(pulses - p0 == int'(VECS[v].pulses), tag_of(VECS[v]), "report count",
          pulses - p0, VECS[v].pulses);
      chk(mism == m0, tag_of(VECS[v]), "reported value", mism - m0, 0);
      chk(id_out == ((VECS[v].pulses != 0) ? VECS[v].id : 44'h0), "R9",
          "id_out held after stream", id_out,
          (VECS[v].pulses != 0) ? VECS[v].id : 44'h0);
    end

    // R10: stream with enable low is ignored and outputs stay cleared
    set_mode(M_CLEAN);
    en = 1'b0;
    p0 = pulses;
    exp_id = 44'h777_1234_ABCD;
    stream(44'h777_1234_ABCD, M_CLEAN, 2);
    chk(pulses == p0, "R10", "reports while disabled", pulses - p0, 0);
    chk(id_out == '0, "R10", "id_out while disabled", id_out, 0);

    // R10: dropping enable mid-capture discards the partial frame
    restart();
    repeat (4) put(lvl_lo);
    marker_and_lead();
    data(44'h2B4_6D8F_0135, 1'b0);
    smp_valid = 1'b0;
    en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    exp_id = 44'h6E1_90C3_A7F2;
    p0 = pulses;
    m0 = mism;
    stream(44'h6E1_90C3_A7F2, M_CLEAN, 2);
    chk(pulses - p0 == 2, "R10", "reports after re-enable", pulses - p0, 2);
    chk(mism == m0, "R10", "stale frame reported", mism - m0, 0);

    // R9: every report lasted one clock
    chk(width_err == 0, "R9", "multi-clock pulses", width_err, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule